// File: doc/BRIEF.md
# Sampling Converter Serial Readout Interface

This block is the digital face of a 16-bit sampling converter. A host raises a convert strobe to start a conversion. The level of the serial data input at that rising edge picks how the block behaves until the next conversion. The result comes from a parallel input and is loaded into a shift register when an internal conversion timer expires. The host then clocks the word out most significant bit first on the serial output. Bits change after each falling edge of the serial clock, so the host captures them on the rising edge.

In chain mode, the serial output is always driven. The serial data input feeds the bottom of the shift register, so several converters can be linked output to input and read over one wire. In select mode, the output is enabled whenever either the convert strobe or the serial data input is low. An optional busy indicator lets the host wait for the end of a conversion by watching the data line.

All inputs are sampled by the system clock, which must run at least twice as fast as the serial clock. The output enable is a separate port from the output value, and the pad tri-state is built outside this block.

Top module: `sar_serial_if`

## Requirements
- R1: At a rising edge of `cnv` that starts a conversion, the block latches the mode from `sdi`: low selects chain mode and high selects select mode. Reset leaves the block in select mode.
- R2: `conv_busy` rises on the clock edge that sees the `cnv` rising edge. It stays high for exactly `CONV_CYCLES` clock cycles and then falls on the same edge that loads `sample_data`.
- R3: A `cnv` rising edge while `conv_busy` is high is ignored. It neither restarts the timer nor changes the latched mode.
- R4: Falling edges of `sck` while `conv_busy` is high do not shift the register.
- R5: The loaded word leaves on `sdo` most significant bit first. The register moves by one bit on each falling edge of `sck` that is seen after the conversion.
- R6: In chain mode, `sdo_en` is 1. At each shift, `sdi` enters the least significant end of the register, so a level on `sdi` reaches `sdo` 16 `sck` cycles later. With two linked devices, 48 `sck` cycles deliver the downstream word, then the upstream word, then the bits fed into the upstream `sdi`.
- R7: In select mode, `sdo_en` equals `!cnv || !sdi`.
- R8: In select mode, `sdo` is 1 while `conv_busy` is high.
- R9: In select mode, if `cnv` or `sdi` is low on the completion edge, the busy indicator is armed. `sdo` goes to 0 and stays there until the next `sck` falling edge, which presents the most significant bit without shifting.
- R10: In select mode, if `cnv` and `sdi` are both high on the completion edge, the most significant bit is on `sdo` as soon as `conv_busy` falls.
- R11: After reset, `conv_busy` is 0, `sdo` is 0, and a `cnv` held high through reset does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe; its rising edge starts a conversion |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Mode select at the strobe edge; chain input or output enable afterwards |
| sample_data | input | DATA_W | Conversion result, taken when the timer expires |
| sdo | output | 1 | Serial data output value |
| sdo_en | output | 1 | Output enable for the external tri-state driver |
| conv_busy | output | 1 | High while a conversion is in progress |

## Verification
The bench builds two instances with `DATA_W` = 16 and `CONV_CYCLES` = 12. The short conversion leaves room for many full rounds. Linking the upstream output to the downstream input lets 48 serial clocks show both results, followed by the pass-through bits that arrive exactly 16 cycles later. With twelve busy cycles, the bench can toggle `sck` and re-raise `cnv` in the middle of a conversion and still see the completion edge land on the predicted cycle. This covers all three select-mode variants: indicator armed by `cnv`, armed by `sdi`, and not armed.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;

  typedef enum logic {
    MODE_CHAIN  = 1'b0,
    MODE_SELECT = 1'b1
  } if_mode_e;

  // Mode chosen by the level of the data input at the strobe edge
  function automatic if_mode_e mode_from_sdi(input logic level);
    return level ? MODE_SELECT : MODE_CHAIN;
  endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic edge_o
);

  // Reset value equals the idle level of the watched edge, so no edge is
  // reported on the first clock after reset.
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= RISING;
    else        sig_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~sig_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & sig_q;
    end
  endgenerate

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int unsigned CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CW = $clog2(CYCLES + 1);

  function automatic logic [CW-1:0] first_count();
    return CW'(CYCLES - 1);
  endfunction

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= first_count();
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R2
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

endmodule

// File: rtl/sar_shift_reg.sv
module sar_shift_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] word_o
);

  function automatic logic [WIDTH-1:0] next_word(input logic [WIDTH-1:0] w,
                                                 input logic b);
    return {w[WIDTH-2:0], b};
  endfunction

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (load_i)  word_q <= load_val_i;
    else if (shift_i) word_q <= next_word(word_q, ser_i);
  end

  assign word_o = word_q;

  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (word_o == $past(load_val_i)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(word_o));

endmodule

// File: rtl/sar_serial_if.sv
module sar_serial_if
  import sar_if_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] sample_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              conv_busy
);

  localparam int unsigned MSB = DATA_W - 1;

  // Named internal events
  logic              cnv_rise;
  logic              sck_fall;
  logic              conv_start;
  logic              conv_active;
  logic              conv_done;
  logic              shift_en;
  logic              shift_bit;
  logic              ind_arm;
  logic [DATA_W-1:0] data_word;
  if_mode_e          mode_q;
  logic              ind_pending;

  sar_edge_det #(.RISING(1'b1)) u_cnv_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(cnv), .edge_o(cnv_rise));

  sar_edge_det #(.RISING(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(sck), .edge_o(sck_fall));

  assign conv_start = cnv_rise && !conv_active;

  sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start),
    .busy_o(conv_active), .done_o(conv_done));

  // Busy indicator armed when either enable line is low at completion
  assign ind_arm   = (mode_q == MODE_SELECT) && (!cnv || !sdi);
  assign shift_en  = sck_fall && !conv_active && !ind_pending;
  assign shift_bit = (mode_q == MODE_CHAIN) ? sdi : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_SELECT;
      ind_pending <= 1'b0;
    end else if (conv_start) begin
      mode_q      <= mode_from_sdi(sdi);
      ind_pending <= 1'b0;
    end else if (conv_done) begin
      ind_pending <= ind_arm;
    end else if (sck_fall && !conv_active) begin
      ind_pending <= 1'b0;
    end
  end

  sar_shift_reg #(.WIDTH(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(conv_done), .load_val_i(sample_data),
    .shift_i(shift_en), .ser_i(shift_bit), .word_o(data_word));

  always_comb begin
    if (mode_q == MODE_CHAIN) begin
      sdo    = data_word[MSB];
      sdo_en = 1'b1;
    end else begin
      sdo_en = !cnv || !sdi;
      if (conv_active)      sdo = 1'b1;
      else if (ind_pending) sdo = 1'b0;
      else                  sdo = data_word[MSB];
    end
  end

  assign conv_busy = conv_active;

  // R1
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (mode_q == ($past(sdi) ? MODE_SELECT : MODE_CHAIN)));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_active |=> $stable(mode_q));

  // R4
  sck_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && !conv_done) |=> $stable(data_word));

  // R6
  chain_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CHAIN) |-> sdo_en);

  // R8
  select_busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_SELECT) && conv_active) |-> sdo);

  // R9
  indicator_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (mode_q == MODE_SELECT) && (!cnv || !sdi)) |=> !sdo);

endmodule

// File: tb/sar_serial_if_bench.sv
module sar_serial_if_bench;

  localparam int unsigned W = 16;
  localparam int unsigned C = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv = 1'b1;
  logic         sck = 1'b0;
  logic         up_sdi = 1'b0;
  logic         ds_sdi = 1'b1;
  logic         link = 1'b0;
  logic [W-1:0] a_data = '0;
  logic [W-1:0] b_data = '0;
  logic         up_sdo, up_en, up_busy;
  logic         dn_sdo, dn_en, dn_busy;
  logic         dn_sdi;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign dn_sdi = link ? up_sdo : ds_sdi;

  sar_serial_if #(.DATA_W(W), .CONV_CYCLES(C)) u_sar_serial_if_up (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(up_sdi),
    .sample_data(a_data), .sdo(up_sdo), .sdo_en(up_en), .conv_busy(up_busy));

  sar_serial_if #(.DATA_W(W), .CONV_CYCLES(C)) u_sar_serial_if (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(dn_sdi),
    .sample_data(b_data), .sdo(dn_sdo), .sdo_en(dn_en), .conv_busy(dn_busy));

  // Expected bit k (1-based) of a 48-bit chained read: downstream, upstream, pass-through
  function automatic logic chain_bit(input logic [W-1:0] b, input logic [W-1:0] a,
                                     input logic [W-1:0] p, input int k);
    logic [3*W-1:0] stream;
    stream = {b, a, p};
    return stream[3*W - k];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck = 1'b1; step();
    sck = 1'b0; step();
  endtask

  // Wait from busy cycle 'from' to busy cycle C, optionally toggling sck (R4)
  task automatic busy_wait(input int from, input bit toggle);
    for (int n = from; n <= C; n++) begin
      if (toggle && n < C - 2) sck = ~sck;
      else sck = 1'b0;
      step();
    end
  endtask

  task automatic chain_round(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [W-1:0] p, input bit toggle);
    link = 1'b0; up_sdi = 1'b0; ds_sdi = 1'b0; cnv = 1'b0;
    a_data = a; b_data = b;
    step();
    cnv = 1'b1; step();
    check("R2 busy after strobe", 16'(dn_busy), 16'd1);
    link = 1'b1;
    busy_wait(2, toggle);
    check("R2 busy at last cycle", 16'(dn_busy), 16'd1);
    step();
    check("R2 busy cleared", 16'(dn_busy), 16'd0);
    check("R1 R6 chain enable down", 16'(dn_en), 16'd1);
    check("R1 R6 chain enable up", 16'(up_en), 16'd1);
    for (int k = 1; k <= 3 * W; k++) begin
      check("R6 R5 chained bit", 16'(dn_sdo), 16'(chain_bit(b, a, p, k)));
      up_sdi = (k <= W) ? p[W - k] : 1'b0;
      sck_pulse();
    end
    cnv = 1'b0; link = 1'b0; step();
  endtask

  // variant 0: cnv low at completion, 1: sdi low at completion, 2: both high
  task automatic select_round(input int variant, input logic [W-1:0] v, input bit toggle);
    link = 1'b0; cnv = 1'b0; ds_sdi = 1'b1; b_data = v;
    step();
    cnv = 1'b1; step();
    check("R2 busy after strobe", 16'(dn_busy), 16'd1);
    if (variant == 0) cnv = 1'b0;
    if (variant == 1) ds_sdi = 1'b0;
    step();
    check("R7 select enable", 16'(dn_en), (variant == 2) ? 16'd0 : 16'd1);
    if (variant != 2) check("R8 high during conversion", 16'(dn_sdo), 16'd1);
    busy_wait(3, toggle);
    check("R2 busy at last cycle", 16'(dn_busy), 16'd1);
    if (variant != 2) check("R8 high after sck activity", 16'(dn_sdo), 16'd1);
    step();
    check("R2 busy cleared", 16'(dn_busy), 16'd0);
    if (variant != 2) begin
      check("R9 indicator low", 16'(dn_sdo), 16'd0);
      step();
      check("R9 indicator holds low", 16'(dn_sdo), 16'd0);
      sck_pulse();
      check("R9 msb after first fall", 16'(dn_sdo), 16'(v[W-1]));
    end else begin
      check("R7 disabled with both high", 16'(dn_en), 16'd0);
      check("R10 msb at completion", 16'(dn_sdo), 16'(v[W-1]));
      cnv = 1'b0; step();
      check("R7 enabled by low cnv", 16'(dn_en), 16'd1);
    end
    for (int k = W - 1; k >= 0; k--) begin
      check("R5 select bit", 16'(dn_sdo), 16'(v[k]));
      sck_pulse();
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11: strobe held high through reset starts nothing
    check("R11 busy idle", 16'(dn_busy), 16'd0);
    check("R11 sdo low", 16'(dn_sdo), 16'd0);
    check("R1 R7 reset select mode disabled", 16'(dn_en), 16'd0);
    cnv = 1'b0; step();
    check("R7 enabled by low cnv", 16'(dn_en), 16'd1);

    // Directed corners
    chain_round(16'h8000, 16'h0001, 16'hA5C3, 1'b0);
    chain_round(16'hFFFF, 16'h0000, 16'h0F0F, 1'b1);
    select_round(0, 16'hFFFF, 1'b1);
    select_round(1, 16'h0000, 1'b0);
    select_round(2, 16'h8001, 1'b1);

    // R3: second strobe during conversion neither restarts nor changes mode
    cnv = 1'b0; ds_sdi = 1'b1; b_data = 16'h1234; step();
    cnv = 1'b1; step();
    cnv = 1'b0; ds_sdi = 1'b0; step();
    cnv = 1'b1; step();
    busy_wait(4, 1'b0);
    check("R3 no restart busy", 16'(dn_busy), 16'd1);
    step();
    check("R3 no restart done", 16'(dn_busy), 16'd0);
    ds_sdi = 1'b1; step();
    check("R3 mode kept select", 16'(dn_en), 16'd0);

    // Random rounds
    for (int i = 0; i < 6; i++)
      chain_round(16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    for (int i = 0; i < 9; i++)
      select_round(i % 3, 16'($urandom), 1'($urandom));

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule